// File: doc/BRIEF.md
# Vital Product Data Capability Controller

This block holds the registers of a vital-product-data capability and performs the exchange of 32-bit words between its data register and a backing byte store. Software reaches it through configuration reads and writes to two dwords. Dword 0 carries the capability ID byte, the next-capability pointer byte and a 16-bit address/flag register. Dword 1 is the 32-bit data register. An internal byte array models the slow non-volatile storage, and it takes a programmable number of cycles per byte.

Software encodes the direction of a transfer in the flag bit that it writes together with the address. A flag of 0 asks for a fetch: the device reads four bytes into the data register and then raises the flag. A flag of 1 asks for a store: software first loads the data register, then writes the address with the flag set, and the device clears the flag once the four bytes are committed. Software learns that a transfer is complete by polling that single bit. The configuration port carries single register accesses, not a data stream, so it has plain pins and no valid/ready handshake. A write completes in the cycle it is presented, and a read returns its data combinationally.

Top module: `vpd_cap_ctrl`

## Requirements
- R1: Dword 0 (cfg_sel=0) reads 0x03 in bits 7:0 and NEXT_PTR (default 0x00) in bits 15:8. Writes never change these two bytes.
- R2: The address/flag register occupies bits 31:16 of dword 0, with the flag in bit 31 and the address in bits 30:16. It resets to 0. It is written only when cfg_be[3] and cfg_be[2] are both set and no transfer is in progress, and it reads back exactly the value written.
- R3: Writing the address with flag 0 fetches the four bytes at the dword-aligned address. The lowest address goes to data bits 7:0 and the highest to bits 31:24. The flag then becomes 1.
- R4: Writing the address with flag 1 stores the data register into the four bytes at the aligned address, little-endian. The flag then becomes 0.
- R5: The flag changes exactly 4*BYTE_LAT clock cycles after the edge that accepted the address write.
- R6: A dword-0 write that arrives while a transfer is in progress is ignored. This includes a write in the cycle where the flag changes. Address and flag are unchanged, and no new transfer starts.
- R7: Writes to the data register (cfg_sel=1) update only the bytes whose cfg_be bit is set, and they do so only while idle. While a transfer is in progress they are ignored. The data register resets to 0.
- R8: Address bits 1:0 do not affect the bytes accessed. Addresses wrap modulo STORE_BYTES (default 256).
- R9: After reset, store byte i holds (37*i + 11) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Dword select: 0 header/address, 1 data |
| cfg_be | input | 4 | Byte enables for a configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data of the selected dword |

## Verification
Two events can land on the same clock edge: completion of a transfer, which flips the flag, and a new address write from software. The bench times a dword-0 write so that it is accepted on exactly the edge that ends a fetch. It then judges the result: the flag shows the completed fetch, the address is the old one, and the fetched word is intact. Further directed cases issue data and address writes in mid-transfer. A seeded random mix of fetches and stores at unaligned and wrapping addresses is compared against a byte-array model kept in the bench.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  localparam logic [7:0] VPD_CAP_ID = 8'h03;

  typedef struct packed {
    logic        flag;
    logic [14:0] addr;
  } vpd_af_t;

  function automatic logic [7:0] seed_byte(input int unsigned i);
    return 8'(i * 37 + 11);
  endfunction
endpackage

// File: rtl/vpd_store.sv
module vpd_store #(
  parameter int STORE_BYTES = 256,
  parameter int BYTE_LAT    = 4,
  localparam int IDX_W = $clog2(STORE_BYTES),
  localparam int LAT_W = (BYTE_LAT > 1) ? $clog2(BYTE_LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wbyte,
  output logic             ack,
  output logic [7:0]       rbyte
);
  import vpd_pkg::*;

  logic [7:0]       mem [STORE_BYTES];
  logic [LAT_W-1:0] wait_q;

  assign ack   = req && (wait_q == LAT_W'(BYTE_LAT - 1));
  assign rbyte = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
      for (int i = 0; i < STORE_BYTES; i++) mem[i] <= seed_byte(i);
    end else begin
      if (!req || ack) wait_q <= '0;
      else             wait_q <= wait_q + 1'b1;
      if (ack && we) mem[idx] <= wbyte;
    end
  end
endmodule

// File: rtl/vpd_engine.sv
module vpd_engine #(
  parameter int STORE_BYTES = 256,
  parameter int BYTE_LAT    = 4,
  localparam int IDX_W = $clog2(STORE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_dir,
  input  logic [IDX_W-3:0] start_dw,
  input  logic             ack,
  input  logic [31:0]      data_q,
  input  logic [7:0]       rbyte,
  output logic             busy,
  output logic             req,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       wbyte,
  output logic             cap_en,
  output logic [1:0]       cap_lane,
  output logic [7:0]       cap_byte,
  output logic             done
);
  logic             busy_q, dir_q;
  logic [IDX_W-3:0] dw_q;
  logic [1:0]       lane_q;
  logic [31:0]      cyc_q;

  assign busy     = busy_q;
  assign req      = busy_q;
  assign we       = dir_q;
  assign idx      = {dw_q, lane_q};
  assign wbyte    = data_q[{lane_q, 3'b000} +: 8];
  assign cap_en   = ack && !dir_q;
  assign cap_lane = lane_q;
  assign cap_byte = rbyte;
  assign done     = ack && (lane_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      dw_q   <= '0;
      lane_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      dir_q  <= start_dir;
      dw_q   <= start_dw;
      lane_q <= '0;
    end else if (ack) begin
      lane_q <= lane_q + 1'b1;
      if (lane_q == 2'd3) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cyc_q <= '0;
    else if (start)  cyc_q <= '0;
    else if (busy_q) cyc_q <= cyc_q + 1;
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == 32'(4 * BYTE_LAT - 1)));
endmodule

// File: rtl/vpd_regs.sv
module vpd_regs #(
  parameter int         STORE_BYTES = 256,
  parameter logic [7:0] NEXT_PTR    = 8'h00,
  localparam int IDX_W = $clog2(STORE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             cap_en,
  input  logic [1:0]       cap_lane,
  input  logic [7:0]       cap_byte,
  output logic             start,
  output logic             start_dir,
  output logic [IDX_W-3:0] start_dw,
  output logic [31:0]      data_q
);
  import vpd_pkg::*;

  vpd_af_t af_q;
  logic    hdr_wr, dat_wr;

  assign hdr_wr    = cfg_wr && !cfg_sel && (cfg_be[3:2] == 2'b11);
  assign dat_wr    = cfg_wr && cfg_sel && !busy;
  assign start     = hdr_wr && !busy;
  assign start_dir = cfg_wdata[31];
  assign start_dw  = cfg_wdata[16+IDX_W-1:18];
  assign cfg_rdata = cfg_sel ? data_q : {af_q, NEXT_PTR, VPD_CAP_ID};

  always_ff @(posedge clk) begin
    if (!rst_n)     af_q <= '0;
    else if (start) af_q <= cfg_wdata[31:16];
    else if (done)  af_q.flag <= ~af_q.flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q[{cap_lane, 3'b000} +: 8] <= cap_byte;
    end else if (dat_wr) begin
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) data_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
    end
  end

  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (af_q == $past(af_q)));

  assert_flag_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (af_q.flag != $past(af_q.flag)));

  assert_data_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && af_q.flag) |=> $stable(data_q));
endmodule

// File: rtl/vpd_cap_ctrl.sv
module vpd_cap_ctrl #(
  parameter int         STORE_BYTES = 256,
  parameter int         BYTE_LAT    = 4,
  parameter logic [7:0] NEXT_PTR    = 8'h00,
  localparam int IDX_W = $clog2(STORE_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata
);
  logic             start, start_dir, busy, req, we, ack, done, cap_en;
  logic [IDX_W-3:0] start_dw;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wbyte, rbyte, cap_byte;
  logic [1:0]       cap_lane;
  logic [31:0]      data_q;

  vpd_regs #(.STORE_BYTES(STORE_BYTES), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_be, .cfg_wdata, .cfg_rdata,
    .busy, .done, .cap_en, .cap_lane, .cap_byte,
    .start, .start_dir, .start_dw, .data_q
  );

  vpd_engine #(.STORE_BYTES(STORE_BYTES), .BYTE_LAT(BYTE_LAT)) u_engine (
    .clk, .rst_n, .start, .start_dir, .start_dw, .ack, .data_q, .rbyte,
    .busy, .req, .we, .idx, .wbyte, .cap_en, .cap_lane, .cap_byte, .done
  );

  vpd_store #(.STORE_BYTES(STORE_BYTES), .BYTE_LAT(BYTE_LAT)) u_store (
    .clk, .rst_n, .req, .we, .idx, .wbyte, .ack, .rbyte
  );

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && (cfg_be[3:2] == 2'b11) && !busy) |=> busy);
endmodule

// File: tb/sim_vpd_cap_ctrl.sv
`timescale 1ns/1ps
module sim_vpd_cap_ctrl;
  localparam int LAT = 3;
  localparam int NB  = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;
  logic [7:0] model [NB];

  always #2.5 clk = ~clk;

  vpd_cap_ctrl #(.STORE_BYTES(NB), .BYTE_LAT(LAT)) u0 (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_be, .cfg_wdata, .cfg_rdata
  );

  function automatic logic [31:0] exp_word(input logic [14:0] a);
    int b;
    b = int'(a & 15'h00FC);
    return {model[b+3], model[b+2], model[b+1], model[b]};
  endfunction

  function automatic logic [31:0] hdr(input logic f, input logic [14:0] a);
    return {f, a, 8'h00, 8'h03};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_read(input logic sel, output logic [31:0] d);
    cfg_sel = sel;
    #0.5;
    d = cfg_rdata;
    cfg_sel = 1'b0;
  endtask

  task automatic wait_flag(input logic f);
    logic [31:0] r;
    for (int i = 0; i < 400; i++) begin
      cfg_read(1'b0, r);
      if (r[31] == f) return;
      @(posedge clk); #1;
    end
  endtask

  task automatic do_fetch(input logic [14:0] a, input string req);
    logic [31:0] r;
    cfg_write(1'b0, 4'hC, {1'b0, a, 16'h0});
    wait_flag(1'b1);
    cfg_read(1'b0, r); check({req, " flag/addr after fetch"}, r, hdr(1'b1, a));
    cfg_read(1'b1, r); check({req, " fetched word"}, r, exp_word(a));
  endtask

  task automatic do_store(input logic [14:0] a, input logic [31:0] d, input string req);
    logic [31:0] r;
    int b;
    cfg_write(1'b1, 4'hF, d);
    cfg_write(1'b0, 4'hC, {1'b1, a, 16'h0});
    wait_flag(1'b0);
    cfg_read(1'b0, r); check({req, " flag/addr after store"}, r, hdr(1'b0, a));
    b = int'(a & 15'h00FC);
    for (int k = 0; k < 4; k++) model[b+k] = d[8*k +: 8];
  endtask

  initial begin
    logic [31:0] r, w0;
    logic [14:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) model[i] = 8'(i * 37 + 11);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R2 R7: reset state
    cfg_read(1'b0, r); check("R1 R2 reset header", r, hdr(1'b0, 15'h0));
    cfg_read(1'b1, r); check("R7 reset data", r, 32'h0);

    // R1: ID and pointer bytes are read-only
    cfg_write(1'b0, 4'h3, 32'hFFFF_FFFF);
    cfg_read(1'b0, r); check("R1 id/next unchanged", r, hdr(1'b0, 15'h0));
    // R2: a partial enable on the address register does nothing
    cfg_write(1'b0, 4'h4, 32'h00AA_0000);
    cfg_read(1'b0, r); check("R2 partial be ignored", r, hdr(1'b0, 15'h0));

    // R5 R9 R3: exact latency, then seeded content
    cfg_write(1'b0, 4'hC, {1'b0, 15'h0010, 16'h0});
    repeat (4*LAT - 1) @(posedge clk);
    #1; cfg_read(1'b0, r); check("R5 flag not yet set", {31'h0, r[31]}, 32'h0);
    @(posedge clk);
    #1; cfg_read(1'b0, r); check("R5 flag set on time", {31'h0, r[31]}, 32'h1);
    cfg_read(1'b1, r); check("R9 R3 seeded word", r, exp_word(15'h0010));

    // R8: low bits ignored, address wraps
    do_fetch(15'h0013, "R8 unaligned");
    do_fetch(15'h0118, "R8 wrap");

    // R7: byte-enabled data write while idle
    cfg_read(1'b1, w0);
    cfg_write(1'b1, 4'b0101, 32'h1122_3344);
    cfg_read(1'b1, r); check("R7 byte enables", r, {w0[31:24], 8'h22, w0[15:8], 8'h44});

    // R4: store and read back
    do_store(15'h0020, 32'hA1B2_C3D4, "R4");
    do_fetch(15'h0020, "R4 readback");

    // R6 R7: writes during a fetch are ignored
    cfg_write(1'b0, 4'hC, {1'b0, 15'h0040, 16'h0});
    cfg_write(1'b0, 4'hC, {1'b1, 15'h0055, 16'h0});
    cfg_write(1'b1, 4'hF, 32'hDEAD_BEEF);
    cfg_read(1'b0, r); check("R6 header write ignored", r, hdr(1'b0, 15'h0040));
    wait_flag(1'b1);
    cfg_read(1'b1, r); check("R7 data write ignored", r, exp_word(15'h0040));
    do_fetch(15'h0054, "R6 no stray store");

    // R6: header write on the completion edge
    cfg_write(1'b0, 4'hC, {1'b0, 15'h0030, 16'h0});
    repeat (4*LAT - 1) @(posedge clk);
    cfg_write(1'b0, 4'hC, {1'b1, 15'h007F, 16'h0});
    cfg_read(1'b0, r); check("R6 same-edge write ignored", r, hdr(1'b1, 15'h0030));
    cfg_read(1'b1, r); check("R6 R3 same-edge data", r, exp_word(15'h0030));

    // R3 R4 R8: random mix
    for (int it = 0; it < 40; it++) begin
      a = 15'($urandom);
      if ($urandom % 2) do_store(a, $urandom, "R4 random");
      else              do_fetch(a, "R3 random");
    end
    for (int it = 0; it < 8; it++) do_fetch(15'($urandom), "R3 random verify");

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule